// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block produces, one per clock, the column addresses that a DDR2-style memory burst visits. A controller first programs a small mode word that selects a burst of four or eight beats and either sequential or interleaved ordering. When a read or write command arrives, the block captures the starting column. It then walks through the beats, showing each column together with a valid flag and a flag that marks the final beat.

Only the three least significant column bits are reordered. All higher bits are passed through unchanged from the starting column. In sequential mode an eight-beat burst is nibble based: the two lowest bits wrap inside a group of four, and then the other group of four follows with the same low-bit pattern. This differs from a plain linear wrap across eight.

The block also enforces the burst rules. There is no stop command, so a burst always runs to its full length unless a permitted interruption occurs. A four-beat burst cannot be interrupted at all. An eight-beat burst can be interrupted only at its halfway point. A command that arrives on the final beat chains into a new burst with no gap. Any other command that arrives during a burst is refused and flagged. A mode change written during a burst waits until that burst has ended.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the block is idle (busy, col_valid, col_last, mode_err and intr_err all low) and the mode is four beats, sequential. The mode word on mr_data uses bits [2:0] for length, where 3'b010 selects 4 beats and 3'b011 selects 8 beats, and bit 3 for ordering, where 0 is sequential and 1 is interleaved.
- R2: A mode write whose length code is anything other than 3'b010 or 3'b011 leaves the mode unchanged and raises mode_err for exactly one cycle, in the cycle after the write.
- R3: A command accepted while the block is idle shows beat 0 in the next cycle. After that, one beat is shown per cycle, with col_valid and busy high. col_last is high only on the final beat. If no new command is accepted on that final beat, col_valid is low in the following cycle.
- R4: For a four-beat sequential burst, beat k has low bits [1:0] equal to start[1:0] + k modulo 4, and bit 2 equal to start bit 2. For example, start 3 gives 3,0,1,2.
- R5: For a four-beat interleaved burst, beat k has low bits [1:0] equal to start[1:0] XOR k, and bit 2 equal to start bit 2. For example, start 1 gives 1,0,3,2.
- R6: For an eight-beat sequential burst, beat k has bits [1:0] equal to start[1:0] + k modulo 4. Bit 2 equals start bit 2 for beats 0 to 3 and its inverse for beats 4 to 7. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R7: For an eight-beat interleaved burst, beat k has bits [2:0] equal to start[2:0] XOR k. For example, start 6 gives 6,7,4,5,2,3,0,1.
- R8: Column bits above bit 2 equal the starting column's bits for every beat. The column width is the parameter COL_W.
- R9: During a four-beat burst, a command presented before the final beat is refused. intr_err pulses high for one cycle in the next cycle, and the burst continues unchanged to its final beat.
- R10: During an eight-beat burst, a command presented in the cycle that shows beat 3 is accepted: the next cycle shows beat 0 of the new burst, and beats 4 to 7 of the old burst are dropped. A command presented on any other non-final beat is refused as in R9.
- R11: A command presented on the final beat of any burst is accepted, and the next cycle shows beat 0 of the new burst with no idle cycle in between.
- R12: A valid mode write made while a burst is running does not change the ordering or length of that burst. It takes effect when that burst ends, so the next burst uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mr_wr | input | 1 | Mode word write strobe |
| mr_data | input | 4 | Mode word: [2:0] length code, [3] ordering |
| cmd_valid | input | 1 | Read or write command present |
| cmd_col | input | COL_W | Starting column of the command |
| busy | output | 1 | A burst is in progress |
| col_valid | output | 1 | col_addr holds a beat address |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |
| mode_err | output | 1 | One-cycle pulse: mode write refused |
| intr_err | output | 1 | One-cycle pulse: command refused |

## Verification
If the beat counter or the latched start column goes wrong, the ports show it in the very next cycle. The low column bits leave the expected nibble pattern, or col_last appears on the wrong beat, so that the burst ends early or runs long. If the mode hold goes wrong, the effect appears only at the next burst boundary. A deferred write that leaks into a running burst changes its length or ordering partway through. The bench therefore checks every beat of every burst, including the beats just after a refused command, an accepted interruption, and a mode write made during a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int          BEAT_W     = 3;
    localparam logic [2:0]  LEN_CODE_4 = 3'b010;
    localparam logic [2:0]  LEN_CODE_8 = 3'b011;

    typedef struct packed {
        logic bl8;   // 1: eight beats, 0: four beats
        logic itl;   // 1: interleaved, 0: sequential
    } burst_mode_t;

    typedef struct packed {
        burst_mode_t cur;
        logic        pend_v;
        burst_mode_t pend;
        logic        err;
    } mode_state_t;
endpackage

// File: rtl/burst_mode_ctl.sv
module burst_mode_ctl
    import burst_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mr_wr,
    input  logic [3:0]  mr_data,
    input  logic        busy,
    input  logic        burst_end,
    output burst_mode_t mode,
    output logic        mode_err
);
    mode_state_t s_d, s_q;
    logic        code_ok;
    burst_mode_t wr_mode;

    always_comb begin
        s_d         = s_q;
        s_d.err     = 1'b0;
        code_ok     = (mr_data[2:0] == LEN_CODE_4) || (mr_data[2:0] == LEN_CODE_8);
        wr_mode.bl8 = (mr_data[2:0] == LEN_CODE_8);
        wr_mode.itl = mr_data[3];
        if (mr_wr) begin
            if (code_ok) begin
                s_d.pend   = wr_mode;
                s_d.pend_v = 1'b1;
            end else begin
                s_d.err = 1'b1;
            end
        end
        // A held mode word is applied only between bursts.
        if (s_d.pend_v && (!busy || burst_end)) begin
            s_d.cur    = s_d.pend;
            s_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode     = s_q.cur;
    assign mode_err = s_q.err;
endmodule

// File: rtl/burst_beat_order.sv
module burst_beat_order
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              itl,
    output logic [COL_W-1:0]  addr
);
    logic [1:0] low;

    // Bit 2 flips after the first nibble in both orderings; for a
    // four-beat burst the beat index never reaches 4, so it holds.
    always_comb begin
        low = itl ? (base[1:0] ^ beat[1:0]) : (base[1:0] + beat[1:0]);
    end

    assign addr[2:0] = {base[2] ^ beat[2], low};

    generate
        if (COL_W > BEAT_W) begin : g_upper
            assign addr[COL_W-1:BEAT_W] = base[COL_W-1:BEAT_W];
        end
    endgenerate
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr_wr,
    input  logic [3:0]       mr_data,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    output logic             busy,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_last,
    output logic             mode_err,
    output logic             intr_err
);
    localparam logic [BEAT_W-1:0] LAST_BL4 = BEAT_W'(3);
    localparam logic [BEAT_W-1:0] LAST_BL8 = BEAT_W'(7);
    localparam logic [BEAT_W-1:0] HALF_BL8 = BEAT_W'(3);

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        logic [COL_W-1:0]  base;
        logic              intr_err;
    } seq_state_t;

    seq_state_t  s_d, s_q;
    burst_mode_t mode;
    logic        last_beat, half_ok, take, burst_end;
    logic        cur_itl;

    burst_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mr_wr     (mr_wr),
        .mr_data   (mr_data),
        .busy      (s_q.active),
        .burst_end (burst_end),
        .mode      (mode),
        .mode_err  (mode_err)
    );

    always_comb begin
        last_beat = s_q.active && (s_q.beat == (mode.bl8 ? LAST_BL8 : LAST_BL4));
        half_ok   = s_q.active && mode.bl8 && (s_q.beat == HALF_BL8);
        take      = cmd_valid && (!s_q.active || last_beat || half_ok);
        burst_end = last_beat || (cmd_valid && half_ok);

        s_d          = s_q;
        s_d.intr_err = cmd_valid && !take;
        if (take) begin
            s_d.active = 1'b1;
            s_d.beat   = '0;
            s_d.base   = cmd_col;
        end else if (last_beat) begin
            s_d.active = 1'b0;
            s_d.beat   = '0;
        end else if (s_q.active) begin
            s_d.beat = s_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    burst_beat_order #(.COL_W(COL_W)) u_order (
        .base (s_q.base),
        .beat (s_q.beat),
        .itl  (mode.itl),
        .addr (col_addr)
    );

    assign cur_itl   = mode.itl;
    assign busy      = s_q.active;
    assign col_valid = s_q.active;
    assign col_last  = last_beat;
    assign intr_err  = s_q.intr_err;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mr_wr,
    input logic             cmd_valid,
    input logic             col_valid,
    input logic             col_last,
    input logic [COL_W-1:0] col_addr,
    input logic             mode_err,
    input logic             intr_err,
    input logic             cur_itl
);
    p_last_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    p_idle_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid);

    p_upper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && !$past(col_last) && !$past(cmd_valid))
        |-> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3])));

    // Sequential ordering, both lengths: low pair steps by one (R4, R6).
    p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && !$past(col_last) && !$past(cmd_valid) && !cur_itl)
        |-> (col_addr[1:0] == $past(col_addr[1:0]) + 2'd1));

    p_refuse_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        intr_err |-> $past(cmd_valid && col_valid && !col_last));

    p_mode_err_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $past(mr_wr));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mr_wr     (mr_wr),
    .cmd_valid (cmd_valid),
    .col_valid (col_valid),
    .col_last  (col_last),
    .col_addr  (col_addr),
    .mode_err  (mode_err),
    .intr_err  (intr_err),
    .cur_itl   (cur_itl)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mr_wr = 1'b0;
    logic [3:0]       mr_data = '0;
    logic             cmd_valid = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             busy, col_valid, col_last, mode_err, intr_err;
    logic [COL_W-1:0] col_addr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .mr_wr(mr_wr), .mr_data(mr_data),
        .cmd_valid(cmd_valid), .cmd_col(cmd_col), .busy(busy),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
        .mode_err(mode_err), .intr_err(intr_err)
    );

    // {mode[3:0], start col[9:0], length[3:0], beats as nibbles, beat 0 first}
    localparam logic [49:0] VEC [0:7] = '{
        {4'b0010, 10'h2A3, 4'd4, 32'h3012_0000},  // R4
        {4'b0010, 10'h1F6, 4'd4, 32'h6745_0000},  // R4
        {4'b1010, 10'h001, 4'd4, 32'h1032_0000},  // R5
        {4'b1010, 10'h3FF, 4'd4, 32'h7654_0000},  // R5
        {4'b0011, 10'h155, 4'd8, 32'h5674_1230},  // R6
        {4'b0011, 10'h0AA, 4'd8, 32'h2301_6745},  // R6
        {4'b1011, 10'h236, 4'd8, 32'h6745_2301},  // R7
        {4'b1011, 10'h3CB, 4'd8, 32'h3210_7654}   // R7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_mode(input logic [3:0] m);
        @(negedge clk); mr_wr = 1'b1; mr_data = m;
        @(negedge clk); mr_wr = 1'b0;
    endtask

    task automatic issue(input logic [COL_W-1:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd_col = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    // Checks beats first..upto-1 starting at the current negedge.
    task automatic beats(input string tag, input logic [COL_W-1:0] c, input int first,
                         input int upto, input int len, input logic [31:0] exp,
                         input bit idle_after);
        for (int b = first; b < upto; b++) begin
            chk({tag, " valid"}, 32'(col_valid), 32'd1);
            chk({tag, " addr"}, 32'(col_addr), 32'({c[COL_W-1:3], exp[(7-b)*4 +: 3]}));
            chk({tag, " last"}, 32'(col_last), 32'(b == len - 1));
            @(negedge clk);
        end
        if (idle_after) chk({tag, " R3 idle after last"}, 32'(col_valid), 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset valid", 32'(col_valid), 0);
        chk("R1 reset last", 32'(col_last), 0);
        chk("R1 reset errs", 32'({mode_err, intr_err}), 0);
        rst_n = 1'b1;
        // R1 default mode: four beats sequential
        issue(10'h002);
        beats("R1 default mode", 10'h002, 0, 4, 4, 32'h2301_0000, 1'b1);

        // Table walk: R4 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            write_mode(VEC[i][49:46]);
            issue(VEC[i][45:36]);
            beats("R8 table", VEC[i][45:36], 0, int'(VEC[i][35:32]),
                  int'(VEC[i][35:32]), VEC[i][31:0], 1'b1);
        end

        // R2 invalid code keeps mode (eight-beat sequential)
        write_mode(4'b0011);
        @(negedge clk); mr_wr = 1'b1; mr_data = 4'b0101;
        @(negedge clk); mr_wr = 1'b0;
        chk("R2 mode_err pulse", 32'(mode_err), 1);
        @(negedge clk);
        chk("R2 mode_err single", 32'(mode_err), 0);
        issue(10'h005);
        beats("R2 mode kept", 10'h005, 0, 8, 8, 32'h5674_1230, 1'b1);

        // R9 four-beat burst refuses interruption
        write_mode(4'b0010);
        issue(10'h100);
        cmd_valid = 1'b1; cmd_col = 10'h3FF;
        beats("R9 beat0", 10'h100, 0, 1, 4, 32'h0123_0000, 1'b0);
        cmd_valid = 1'b0;
        chk("R9 intr_err", 32'(intr_err), 1);
        beats("R9 continue", 10'h100, 1, 2, 4, 32'h0123_0000, 1'b0);
        chk("R9 intr_err single", 32'(intr_err), 0);
        beats("R9 finish", 10'h100, 2, 4, 4, 32'h0123_0000, 1'b1);

        // R10 eight-beat interruption at beat 3
        write_mode(4'b0011);
        issue(10'h040);
        beats("R10 head", 10'h040, 0, 3, 8, 32'h0123_4567, 1'b0);
        cmd_valid = 1'b1; cmd_col = 10'h20D;
        beats("R10 beat3", 10'h040, 3, 4, 8, 32'h0123_4567, 1'b0);
        cmd_valid = 1'b0;
        chk("R10 no error at boundary", 32'(intr_err), 0);
        beats("R10 new burst", 10'h20D, 0, 8, 8, 32'h5674_1230, 1'b1);

        // R10 refused at beat 5
        issue(10'h040);
        beats("R10 head2", 10'h040, 0, 5, 8, 32'h0123_4567, 1'b0);
        cmd_valid = 1'b1; cmd_col = 10'h111;
        beats("R10 beat5", 10'h040, 5, 6, 8, 32'h0123_4567, 1'b0);
        cmd_valid = 1'b0;
        chk("R10 refused beat5", 32'(intr_err), 1);
        beats("R10 tail", 10'h040, 6, 8, 8, 32'h0123_4567, 1'b1);

        // R11 seamless chain on the final beat
        write_mode(4'b0010);
        issue(10'h0C2);
        beats("R11 first", 10'h0C2, 0, 3, 4, 32'h2301_0000, 1'b0);
        cmd_valid = 1'b1; cmd_col = 10'h0C0;
        beats("R11 last", 10'h0C2, 3, 4, 4, 32'h2301_0000, 1'b0);
        cmd_valid = 1'b0;
        chk("R11 no error", 32'(intr_err), 0);
        beats("R11 chained", 10'h0C0, 0, 4, 4, 32'h0123_0000, 1'b1);

        // R12 mode write during a burst is deferred
        issue(10'h300);
        mr_wr = 1'b1; mr_data = 4'b1011;
        beats("R12 beat0", 10'h300, 0, 1, 4, 32'h0123_0000, 1'b0);
        mr_wr = 1'b0;
        beats("R12 old mode", 10'h300, 1, 4, 4, 32'h0123_0000, 1'b1);
        issue(10'h306);
        beats("R12 new mode", 10'h306, 0, 8, 8, 32'h6745_2301, 1'b1);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule